// File: doc/BRIEF.md
# Instruction Group Dependency Checker

This block watches a stream of decoded instructions, one per clock, and checks that the instructions inside one instruction group do not depend on each other. An instruction group is the run of instructions between two stop marks. Each instruction brings:

- up to two source register operands and one destination operand, each with its own register class;
- a branch flag, a check-load flag and a combining-compare kind;
- a flag that places a stop after the instruction.

The block remembers which registers the current group has written. It raises a one-cycle violation when an instruction reads a register written earlier in the group, or writes a register written earlier in the group. Several cases are exempt: write-after-read, a branch reading a predicate or branch register, consumption of a check-load result, and compares of the same combining kind that share a predicate target. The block only reports violations. It does not stall, reorder or repair anything.

The report is combinational. It appears in the same cycle the instruction is on the inputs. The tracking state updates at the clock edge that ends that cycle. An instruction that carries a stop is still checked against its group, and the group is emptied after it.

Top module: `grp_dep_chk`

## Requirements
- R1: A synchronous active-high `rst` empties all tracking. After reset, a read of a register that was written before the reset is not reported.
- R2: Reading a register that an earlier valid instruction of the same group wrote pulses `viol_valid` with `viol_code` = 1 and `viol_reg` set to the register id. The pulse comes in the cycle the reading instruction is presented.
- R3: Writing a register that an earlier instruction of the same group only read is not reported.
- R4: A second write to a register already written in the group gives `viol_code` = 2 and that register id. This holds unless R5 applies.
- R5: Class encoding is 0 general, 1 predicate, 2 branch, and 3 untracked. Compare kind encoding is 0 none, 1 AND-type, 2 OR-type. A predicate target written only by compares of one kind may be written again by a compare of the same kind without a report.
- R6: A compare of one kind that writes a predicate earlier written by a compare of the other kind gives `viol_code` = 3 and the predicate id.
- R7: An instruction with `is_branch` set may read predicate or branch registers written earlier in the group without a report. Without `is_branch`, the same read is reported as in R2.
- R8: A general register whose writes in the group all came from instructions with `is_chkld` set may be read without a report.
- R9: `stop_after` ends the group after the instruction that carries it. That instruction is still checked, and the next instruction sees an empty group.
- R10: General register 0 and predicate register 0 are never tracked. Reading or writing them is never reported.
- R11: While `in_valid` is low, no violation is reported and no tracking state changes. This includes `stop_after`, which then has no effect.
- R12: At most one violation is reported per instruction. The first source takes priority over the second source, and the second source takes priority over the destination. Predicate ids use the low 6 id bits and branch ids use the low 3 id bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| src0_en | input | 1 | First source operand present |
| src0_cls | input | 2 | First source class |
| src0_id | input | 7 | First source register id |
| src1_en | input | 1 | Second source operand present |
| src1_cls | input | 2 | Second source class |
| src1_id | input | 7 | Second source register id |
| dst_en | input | 1 | Destination operand present |
| dst_cls | input | 2 | Destination class |
| dst_id | input | 7 | Destination register id |
| is_branch | input | 1 | Instruction is a branch |
| is_chkld | input | 1 | Instruction is a check-load |
| cmp_kind | input | 2 | Combining compare kind |
| stop_after | input | 1 | Group ends after this instruction |
| viol_valid | output | 1 | Violation pulse for the presented instruction |
| viol_code | output | 2 | 1 read-after-write, 2 write-after-write, 3 mixed compare |
| viol_reg | output | 7 | Offending register id |

## Verification
The stream is built from short groups, and each group ends with a stop.

- Plain read-after-write and write-after-write groups show the basic detection and that the register id is carried through.
- A read-then-write group separates write-after-read from the reverse order.
- Compare pairs of the same kind and of mixed kinds tell the combining exemption apart from the mixed-kind report.
- Branch and non-branch readers of the same predicate show that the exemption is tied to the branch flag.
- A check-load producer shows the consumer exemption.
- Instructions that carry a stop and also violate, idle cycles that carry a stop or a stale read, register zero, and operands hitting several rules at once cover group clearing, the valid gate and report priority.

// File: rtl/grp_dep_chk.sv
module grp_dep_chk #(
  parameter int GR_W = 7,
  parameter int PR_W = 6,
  parameter int BR_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            src0_en,
  input  logic [1:0]      src0_cls,
  input  logic [GR_W-1:0] src0_id,
  input  logic            src1_en,
  input  logic [1:0]      src1_cls,
  input  logic [GR_W-1:0] src1_id,
  input  logic            dst_en,
  input  logic [1:0]      dst_cls,
  input  logic [GR_W-1:0] dst_id,
  input  logic            is_branch,
  input  logic            is_chkld,
  input  logic [1:0]      cmp_kind,
  input  logic            stop_after,
  output logic            viol_valid,
  output logic [1:0]      viol_code,
  output logic [GR_W-1:0] viol_reg
);

  localparam int NGR = 1 << GR_W;
  localparam int NPR = 1 << PR_W;
  localparam int NBR = 1 << BR_W;
  localparam logic [1:0] C_GEN = 2'd0;
  localparam logic [1:0] C_PRD = 2'd1;
  localparam logic [1:0] C_BRN = 2'd2;
  localparam logic [1:0] K_AND = 2'd1;
  localparam logic [1:0] K_OR  = 2'd2;

  logic [NGR-1:0] gr_w, gr_ck;
  logic [NPR-1:0] pr_w, pr_and, pr_or;
  logic [NBR-1:0] br_w;

  function automatic logic [GR_W-1:0] mask_id(input logic [1:0] c, input logic [GR_W-1:0] id);
    logic [GR_W-1:0] m;
    m = id;
    if (c == C_PRD) m = GR_W'(id[PR_W-1:0]);
    else if (c == C_BRN) m = GR_W'(id[BR_W-1:0]);
    return m;
  endfunction

  function automatic logic was_written(input logic [1:0] c, input logic [GR_W-1:0] id);
    logic r;
    case (c)
      C_GEN:   r = gr_w[id];
      C_PRD:   r = pr_w[id[PR_W-1:0]];
      C_BRN:   r = br_w[id[BR_W-1:0]];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic read_exempt(input logic [1:0] c, input logic [GR_W-1:0] id);
    return (is_branch && (c == C_PRD || c == C_BRN)) || (c == C_GEN && gr_ck[id]);
  endfunction

  logic s0_hit, s1_hit, d_hit, is_cmp, same_ok, mixed;
  logic [PR_W-1:0] dp;

  assign dp      = dst_id[PR_W-1:0];
  assign is_cmp  = dst_cls == C_PRD && (cmp_kind == K_AND || cmp_kind == K_OR);
  assign same_ok = is_cmp && ((cmp_kind == K_AND) ? pr_and[dp] : pr_or[dp]);
  assign mixed   = is_cmp && ((cmp_kind == K_AND) ? pr_or[dp] : pr_and[dp]);

  assign s0_hit = in_valid && src0_en && was_written(src0_cls, src0_id) && !read_exempt(src0_cls, src0_id);
  assign s1_hit = in_valid && src1_en && was_written(src1_cls, src1_id) && !read_exempt(src1_cls, src1_id);
  assign d_hit  = in_valid && dst_en && was_written(dst_cls, dst_id) && !same_ok;

  always_comb begin
    viol_valid = 1'b0;
    viol_code  = 2'd0;
    viol_reg   = '0;
    if (s0_hit) begin
      viol_valid = 1'b1;
      viol_code  = 2'd1;
      viol_reg   = mask_id(src0_cls, src0_id);
    end else if (s1_hit) begin
      viol_valid = 1'b1;
      viol_code  = 2'd1;
      viol_reg   = mask_id(src1_cls, src1_id);
    end else if (d_hit) begin
      viol_valid = 1'b1;
      viol_code  = mixed ? 2'd3 : 2'd2;
      viol_reg   = mask_id(dst_cls, dst_id);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (in_valid && stop_after)) begin
      gr_w   <= '0;
      gr_ck  <= '0;
      pr_w   <= '0;
      pr_and <= '0;
      pr_or  <= '0;
      br_w   <= '0;
    end else if (in_valid && dst_en) begin
      case (dst_cls)
        C_GEN: if (dst_id != '0) begin
          gr_w[dst_id]  <= 1'b1;
          gr_ck[dst_id] <= (!gr_w[dst_id] || gr_ck[dst_id]) && is_chkld;
        end
        C_PRD: if (dp != '0) begin
          pr_w[dp]   <= 1'b1;
          pr_and[dp] <= (!pr_w[dp] || pr_and[dp]) && cmp_kind == K_AND;
          pr_or[dp]  <= (!pr_w[dp] || pr_or[dp]) && cmp_kind == K_OR;
        end
        C_BRN: br_w[dst_id[BR_W-1:0]] <= 1'b1;
        default: ;
      endcase
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !viol_valid);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stop_after) |=> !viol_valid);

  p_code_set_r2: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> viol_code != 2'd0);

  p_gen_tracked_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stop_after && dst_en && dst_cls == C_GEN && dst_id != '0) |=> gr_w[$past(dst_id)]);

  p_zero_free_r10: assert property (@(posedge clk) disable iff (rst)
    !gr_w[0] && !pr_w[0]);

endmodule

// File: tb/grp_dep_chk_bench.sv
module grp_dep_chk_bench;
  logic clk = 1'b0;
  logic rst;
  logic vld, s0e, s1e, de, br, ck, stp;
  logic [1:0] s0c, s1c, dc, kind;
  logic [6:0] s0i, s1i, di;
  logic viol_valid;
  logic [1:0] viol_code;
  logic [6:0] viol_reg;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  grp_dep_chk u_grp_dep_chk (
    .clk(clk), .rst(rst), .in_valid(vld),
    .src0_en(s0e), .src0_cls(s0c), .src0_id(s0i),
    .src1_en(s1e), .src1_cls(s1c), .src1_id(s1i),
    .dst_en(de), .dst_cls(dc), .dst_id(di),
    .is_branch(br), .is_chkld(ck), .cmp_kind(kind), .stop_after(stp),
    .viol_valid(viol_valid), .viol_code(viol_code), .viol_reg(viol_reg)
  );

  task automatic clr;
    vld = 1'b1; s0e = 0; s1e = 0; de = 0; br = 0; ck = 0; stp = 0;
    s0c = 0; s1c = 0; dc = 0; kind = 0; s0i = 0; s1i = 0; di = 0;
  endtask

  task automatic rd0(input logic [1:0] c, input logic [6:0] i);
    clr; s0e = 1; s0c = c; s0i = i;
  endtask

  task automatic wr(input logic [1:0] c, input logic [6:0] i);
    clr; de = 1; dc = c; di = i;
  endtask

  task automatic go(input logic ev, input logic [1:0] ec, input logic [6:0] er, input string tag);
    #1;
    total++;
    if (viol_valid !== ev || (ev && (viol_code !== ec || viol_reg !== er))) begin
      bad++;
      $display("FAIL %s: got v=%0b code=%0d reg=%0d, want v=%0b code=%0d reg=%0d",
               tag, viol_valid, viol_code, viol_reg, ev, ec, er);
    end
    @(negedge clk);
  endtask

  task automatic endgrp;
    clr; stp = 1; go(0, 0, 0, "stop");
  endtask

  task automatic t_reset;
    clr; vld = 0; go(0, 0, 0, "R1 idle after reset");
    wr(0, 5); go(0, 0, 0, "R1 write");
    rst = 1; clr; vld = 0; @(negedge clk); rst = 0;
    rd0(0, 5); go(0, 0, 0, "R1 reset clears");
    endgrp;
  endtask

  task automatic t_raw;
    wr(0, 10); go(0, 0, 0, "R2 producer");
    clr; s1e = 1; s1i = 10; go(1, 1, 10, "R2 raw general");
    endgrp;
  endtask

  task automatic t_war;
    rd0(0, 20); go(0, 0, 0, "R3 reader");
    wr(0, 20); go(0, 0, 0, "R3 war allowed");
    endgrp;
  endtask

  task automatic t_waw;
    wr(0, 30); go(0, 0, 0, "R4 first write");
    wr(0, 30); go(1, 2, 30, "R4 waw");
    wr(2, 4); go(0, 0, 0, "R4 branch write");
    wr(2, 4); go(1, 2, 4, "R4 waw branch");
    endgrp;
  endtask

  task automatic t_cmp;
    wr(1, 7); kind = 1; go(0, 0, 0, "R5 and first");
    wr(1, 7); kind = 1; go(0, 0, 0, "R5 and again");
    wr(1, 8); kind = 2; go(0, 0, 0, "R5 or first");
    wr(1, 8); kind = 2; go(0, 0, 0, "R5 or again");
    wr(1, 9); kind = 1; go(0, 0, 0, "R6 and first");
    wr(1, 9); kind = 2; go(1, 3, 9, "R6 mixed");
    wr(1, 11); go(0, 0, 0, "R6 plain pred write");
    wr(1, 11); kind = 1; go(1, 2, 11, "R4 cmp over plain");
    endgrp;
  endtask

  task automatic t_branch;
    wr(1, 3); go(0, 0, 0, "R7 pred producer");
    rd0(1, 3); br = 1; go(0, 0, 0, "R7 branch reads pred");
    wr(2, 2); go(0, 0, 0, "R7 br producer");
    rd0(2, 2); br = 1; go(0, 0, 0, "R7 branch reads br");
    rd0(1, 3); go(1, 1, 3, "R7 non-branch reads pred");
    endgrp;
  endtask

  task automatic t_chkld;
    wr(0, 40); ck = 1; go(0, 0, 0, "R8 check-load");
    rd0(0, 40); go(0, 0, 0, "R8 consumer allowed");
    endgrp;
  endtask

  task automatic t_stop;
    wr(0, 50); stp = 1; go(0, 0, 0, "R9 write with stop");
    rd0(0, 50); go(0, 0, 0, "R9 read after stop");
    wr(0, 51); go(0, 0, 0, "R9 producer");
    rd0(0, 51); stp = 1; go(1, 1, 51, "R9 stop instr still checked");
    rd0(0, 51); go(0, 0, 0, "R9 cleared after");
    endgrp;
  endtask

  task automatic t_zero;
    wr(0, 0); go(0, 0, 0, "R10 write r0");
    rd0(0, 0); go(0, 0, 0, "R10 read r0");
    wr(1, 0); go(0, 0, 0, "R10 write p0");
    wr(1, 0); go(0, 0, 0, "R10 rewrite p0");
    endgrp;
  endtask

  task automatic t_invalid;
    wr(0, 60); vld = 0; go(0, 0, 0, "R11 idle write");
    rd0(0, 60); go(0, 0, 0, "R11 idle write ignored");
    endgrp;
    wr(0, 61); go(0, 0, 0, "R11 producer");
    rd0(0, 61); vld = 0; go(0, 0, 0, "R11 idle no pulse");
    clr; vld = 0; stp = 1; go(0, 0, 0, "R11 idle stop");
    rd0(0, 61); go(1, 1, 61, "R11 idle stop ignored");
    endgrp;
  endtask

  task automatic t_prio;
    wr(0, 70); go(0, 0, 0, "R12 p1");
    wr(0, 71); go(0, 0, 0, "R12 p2");
    rd0(0, 71); s1e = 1; s1i = 70; de = 1; di = 70; go(1, 1, 71, "R12 src0 first");
    clr; s1e = 1; s1i = 70; de = 1; di = 71; go(1, 1, 70, "R12 src1 over dst");
    wr(0, 71); go(1, 2, 71, "R12 dst only");
    wr(1, 7'd69); go(0, 0, 0, "R12 pred id masked write");
    rd0(1, 7'd5); go(1, 1, 5, "R12 pred id masked read");
    endgrp;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got hung, want finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; clr; vld = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_raw; t_war; t_waw; t_cmp; t_branch;
    t_chkld; t_stop; t_zero; t_invalid; t_prio;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule